// File: doc/BRIEF.md
# Leaf Interrupt Status Unit

This unit collects three error events raised by a block's datapath (a checksum failure, a bad length, and an uncorrectable memory error). It latches each event into a status bit that hardware can set and only software can clear. Each latched bit is then masked twice, once by an interrupt enable register and once by a halt enable register. The unit drives one interrupt line and one halt line. A higher level of the interrupt tree can OR these lines with those of other blocks.

A 4-bit identifier of the bus agent that was active during an uncorrectable memory error is kept in a sticky field of the status register. Software uses it to diagnose the error. This field never drives either output. Software reaches the three registers through a simple port: an address, write data, a write strobe, a read strobe and read data. A read returns data in the same cycle as its strobe. A write takes effect at the next rising clock edge.

Top module: `leaf_irq_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the registers take their reset values. Status bits and the agent field become 0. The interrupt enable becomes 3'b011 (checksum and length events on, memory event off). The halt enable becomes 3'b100 (only the memory event on). Both outputs then read 0.
- R2: Status bit positions are: bit 0 for the checksum event, bit 1 for the length event, bit 2 for the memory error event. A bit is set at the first rising edge where its event input is high. It stays set after the input returns low.
- R3: A write to offset 0x0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: If a clear and an active event for the same status bit meet at one edge, the bit ends up set.
- R5: The agent field sits at status bits [7:4]. While the field is 0, an edge with the memory event high loads `err_agent` into it. While the field is non-zero, it keeps its value through further memory events. It changes only when bits are cleared by writing 1 to status bits [7:4].
- R6: The agent field has no effect on `irq_o` or `halt_o`.
- R7: `irq_o` is high exactly when some status bit and the matching interrupt enable bit (offset 0x4, bits [2:0]) are both 1.
- R8: `halt_o` is high exactly when some status bit and the matching halt enable bit (offset 0x8, bits [2:0]) are both 1.
- R9: Writes to offset 0x4 and offset 0x8 load bits [2:0] of the write data into the enable register at that offset. Reads of either offset return the stored enables with all upper bits 0.
- R10: A read of any address other than 0x0, 0x4 or 0x8 returns 0. `rd_data` is also 0 while `rd_en` is low. Status bit 3 and bits [31:8] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_crc | input | 1 | Checksum error event |
| evt_len | input | 1 | Length error event |
| evt_ecc | input | 1 | Uncorrectable memory error event |
| err_agent | input | 4 | Identifier of the agent active during the memory error |
| addr | input | ADDR_W (4) | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Masked OR of status for interrupts |
| halt_o | output | 1 | Masked OR of status for halts |

## Verification
The bound checker watches several properties on every cycle:
- a status bit is never lost without a clear;
- the agent field holds while it is non-zero and not being cleared;
- an enabled event raises the matching output on the next cycle;
- reads of unmapped addresses return zero.

Some behaviours only show up in the bench's scenarios, which compare every read and both outputs against a reference model in the bench:
- the exact result when a clear and an event collide;
- the agent field ignoring a zero identifier and later ones;
- enable writes retargeting the outputs;
- the reset values of all three registers.

// File: rtl/leaf_irq_pkg.sv
// Shared constants for the leaf interrupt status unit.
// Assumes the agent field sits above the event bits in the status word.
package leaf_irq_pkg;
    localparam int NUM_EVT    = 3;
    localparam int AGENT_W    = 4;
    localparam int AGENT_LSB  = 4;
    localparam logic [NUM_EVT-1:0] IE_RST = 3'b011;
    localparam logic [NUM_EVT-1:0] HE_RST = 3'b100;
    localparam int OFS_STATUS = 'h0;
    localparam int OFS_IRQEN  = 'h4;
    localparam int OFS_HALTEN = 'h8;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_IRQEN  = 2'd2,
        SEL_HALTEN = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/leaf_irq_status.sv
// Status register: one set-by-hardware, write-one-to-clear bit per event,
// plus a sticky agent field loaded by the memory error event while empty.
// Assumes the memory error event is the most significant event bit.
module leaf_irq_status #(
    parameter int NUM_EVT = 3,
    parameter int AGENT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [AGENT_W-1:0] agent_in,
    input  logic               clr_en,
    input  logic [NUM_EVT-1:0] clr_evt,
    input  logic [AGENT_W-1:0] clr_agent,
    output logic [NUM_EVT-1:0] stat_q,
    output logic [AGENT_W-1:0] agent_q
);
    localparam int ECC_IDX = NUM_EVT - 1;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_bit
            // Per-bit capture: an event outranks a clear on the same edge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[gi] <= 1'b0;
                else if (evt[gi])
                    stat_q[gi] <= 1'b1;
                else if (clr_en && clr_evt[gi])
                    stat_q[gi] <= 1'b0;
            end
        end
    endgenerate

    // Agent field: loads only when empty, otherwise holds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            agent_q <= '0;
        else if (agent_q == '0 && evt[ECC_IDX])
            agent_q <= agent_in;
        else if (clr_en)
            agent_q <= agent_q & ~clr_agent;
    end
endmodule

// File: rtl/leaf_irq_mask.sv
// Software-owned enable register with a parameterised reset value.
// Assumes the write strobe is already qualified by the address decode.
module leaf_irq_mask #(
    parameter int                 NUM_EVT = 3,
    parameter logic [NUM_EVT-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] q
);
    // Load on write, return to the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/leaf_irq_reduce.sv
// Masks the status vector with an enable vector and ORs the result.
// Purely combinational; assumes both vectors share bit positions.
module leaf_irq_reduce #(
    parameter int NUM_EVT = 3
) (
    input  logic [NUM_EVT-1:0] stat,
    input  logic [NUM_EVT-1:0] en,
    output logic               any_o
);
    logic [NUM_EVT:0] chain;

    assign chain[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_or
            assign chain[gi+1] = chain[gi] | (stat[gi] & en[gi]);
        end
    endgenerate
    assign any_o = chain[NUM_EVT];
endmodule

// File: rtl/leaf_irq_unit.sv
// Leaf interrupt status unit: latches three error events, keeps a sticky
// agent identifier, and drives interrupt and halt lines through two masks.
// Assumes word-aligned accesses; any other address is unmapped.
module leaf_irq_unit
    import leaf_irq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_crc,
    input  logic              evt_len,
    input  logic              evt_ecc,
    input  logic [3:0]        err_agent,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o,
    output logic              halt_o
);
    localparam int AGENT_MSB = AGENT_LSB + AGENT_W - 1;

    reg_sel_e            sel;
    logic [NUM_EVT-1:0]  evt_vec;
    logic [NUM_EVT-1:0]  stat_q;
    logic [AGENT_W-1:0]  agent_q;
    logic [NUM_EVT-1:0]  ie_q;
    logic [NUM_EVT-1:0]  he_q;

    assign evt_vec = {evt_ecc, evt_len, evt_crc};

    // Address decode into a register select.
    always_comb begin
        if (addr == ADDR_W'(OFS_STATUS))
            sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFS_IRQEN))
            sel = SEL_IRQEN;
        else if (addr == ADDR_W'(OFS_HALTEN))
            sel = SEL_HALTEN;
        else
            sel = SEL_NONE;
    end

    leaf_irq_status #(.NUM_EVT(NUM_EVT), .AGENT_W(AGENT_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_vec),
        .agent_in  (err_agent),
        .clr_en    (wr_en && sel == SEL_STATUS),
        .clr_evt   (wr_data[NUM_EVT-1:0]),
        .clr_agent (wr_data[AGENT_MSB:AGENT_LSB]),
        .stat_q    (stat_q),
        .agent_q   (agent_q)
    );

    leaf_irq_mask #(.NUM_EVT(NUM_EVT), .RST_VAL(IE_RST)) u_irq_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && sel == SEL_IRQEN),
        .wdata (wr_data[NUM_EVT-1:0]),
        .q     (ie_q)
    );

    leaf_irq_mask #(.NUM_EVT(NUM_EVT), .RST_VAL(HE_RST)) u_halt_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && sel == SEL_HALTEN),
        .wdata (wr_data[NUM_EVT-1:0]),
        .q     (he_q)
    );

    leaf_irq_reduce #(.NUM_EVT(NUM_EVT)) u_irq_or (
        .stat  (stat_q),
        .en    (ie_q),
        .any_o (irq_o)
    );

    leaf_irq_reduce #(.NUM_EVT(NUM_EVT)) u_halt_or (
        .stat  (stat_q),
        .en    (he_q),
        .any_o (halt_o)
    );

    // Read mux: same-cycle data, zero when idle or unmapped.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: begin
                    rd_data[NUM_EVT-1:0]         = stat_q;
                    rd_data[AGENT_MSB:AGENT_LSB] = agent_q;
                end
                SEL_IRQEN:  rd_data[NUM_EVT-1:0] = ie_q;
                SEL_HALTEN: rd_data[NUM_EVT-1:0] = he_q;
                default:    rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/leaf_irq_chk.sv
// Temporal checks on the leaf interrupt status unit, bound to its top.
module leaf_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  evt_vec,
    input logic [3:0]  err_agent,
    input logic [3:0]  addr,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [2:0]  stat_q,
    input logic [3:0]  agent_q,
    input logic [2:0]  ie_q,
    input logic [2:0]  he_q,
    input logic        irq_o,
    input logic        halt_o
);
    logic stat_wr;
    assign stat_wr = wr_en && addr == 4'h0;

    // R2: an event is latched by the next cycle
    a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != 3'b0) |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));

    // R3: without a status write no status bit drops
    a_r3_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R5: a non-zero agent field holds unless a status write targets it
    a_r5_agent_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (agent_q != 4'h0 && !(stat_wr && wr_data[7:4] != 4'h0)) |=> $stable(agent_q));

    // R7: enabled checksum event raises the interrupt line next cycle
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec[0] && ie_q[0] && !(wr_en && addr == 4'h4)) |=> irq_o);

    // R8: enabled memory error raises the halt line next cycle
    a_r8_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec[2] && he_q[2] && !(wr_en && addr == 4'h8)) |=> halt_o);

    // R10: unmapped or idle reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (addr != 4'h0 && addr != 4'h4 && addr != 4'h8)) |-> rd_data == 32'h0);
endmodule

bind leaf_irq_unit leaf_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_vec   (evt_vec),
    .err_agent (err_agent),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .stat_q    (stat_q),
    .agent_q   (agent_q),
    .ie_q      (ie_q),
    .he_q      (he_q),
    .irq_o     (irq_o),
    .halt_o    (halt_o)
);

// File: tb/tb_leaf_irq_unit.sv
module tb_leaf_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_crc = 0, evt_len = 0, evt_ecc = 0;
    logic [3:0]  err_agent = 0;
    logic [3:0]  addr = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        irq_o, halt_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference state
    logic [2:0] m_stat, m_ie, m_he;
    logic [3:0] m_agent;

    always #4 clk = ~clk;

    leaf_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_crc(evt_crc), .evt_len(evt_len),
        .evt_ecc(evt_ecc), .err_agent(err_agent), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .irq_o(irq_o), .halt_o(halt_o)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic r);
        logic [31:0] v = '0;
        if (r) begin
            if (a == 4'h0)      begin v[2:0] = m_stat; v[7:4] = m_agent; end
            else if (a == 4'h4) v[2:0] = m_ie;
            else if (a == 4'h8) v[2:0] = m_he;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R1: reference reset values
    task automatic model_reset();
        m_stat = 3'b000; m_agent = 4'h0; m_ie = 3'b011; m_he = 3'b100;
    endtask

    // R2-R5, R9: reference update for one edge
    task automatic model_edge();
        logic [2:0] ev = {evt_ecc, evt_len, evt_crc};
        logic swr = wr_en && addr == 4'h0;
        if (!rst_n) begin model_reset(); return; end
        if (m_agent == 4'h0 && evt_ecc) m_agent = err_agent;
        else if (swr) m_agent = m_agent & ~wr_data[7:4];
        if (swr) m_stat = m_stat & ~wr_data[2:0];
        m_stat = m_stat | ev;
        if (wr_en && addr == 4'h4) m_ie = wr_data[2:0];
        if (wr_en && addr == 4'h8) m_he = wr_data[2:0];
    endtask

    // one cycle: drive after negedge, check, then apply edge to model
    task automatic step(input logic [2:0] ev, input logic [3:0] ag, input logic w,
                        input logic r, input logic [3:0] a, input logic [31:0] wd,
                        input string req);
        {evt_ecc, evt_len, evt_crc} = ev;
        err_agent = ag; wr_en = w; rd_en = r; addr = a; wr_data = wd;
        #1;
        check({req, " rd_data"}, rd_data, exp_read(a, r));
        check("R7 irq_o", {31'b0, irq_o}, {31'b0, |(m_stat & m_ie)});
        check("R8 halt_o", {31'b0, halt_o}, {31'b0, |(m_stat & m_he)});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle_rd(input logic [3:0] a, input string req);
        step(3'b000, 4'h0, 1'b0, 1'b1, a, 32'h0, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values visible through reads
        idle_rd(4'h0, "R1 status reset");
        idle_rd(4'h4, "R1 irq enable reset");
        idle_rd(4'h8, "R1 halt enable reset");
        // R10: unmapped and idle reads
        idle_rd(4'hC, "R10 unmapped");
        idle_rd(4'h2, "R10 unaligned");
        step(3'b000, 4'h0, 1'b0, 1'b0, 4'h4, 32'h0, "R10 no strobe");
        // R2: pulse checksum event, bit stays
        step(3'b001, 4'h0, 1'b0, 1'b0, 4'h0, 32'h0, "R2 pulse");
        idle_rd(4'h0, "R2 sticky");
        idle_rd(4'h0, "R2 sticky again");
        // R3: writing zero leaves it, writing one clears it
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'h0, "R3 write zero");
        idle_rd(4'h0, "R3 after w0");
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'h1, "R3 write one");
        idle_rd(4'h0, "R3 after w1");
        // R4: event and clear together on length bit
        step(3'b010, 4'h0, 1'b0, 1'b0, 4'h0, 32'h0, "R4 set");
        step(3'b010, 4'h0, 1'b1, 1'b0, 4'h0, 32'h2, "R4 collide");
        idle_rd(4'h0, "R4 event wins");
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'h2, "R4 clear");
        // R5: zero agent not captured, then capture, then hold
        step(3'b100, 4'h0, 1'b0, 1'b0, 4'h0, 32'h0, "R5 zero agent");
        idle_rd(4'h0, "R5 still empty");
        step(3'b100, 4'hA, 1'b0, 1'b0, 4'h0, 32'h0, "R5 capture");
        step(3'b100, 4'h5, 1'b0, 1'b0, 4'h0, 32'h0, "R5 ignore later");
        idle_rd(4'h0, "R5 held value");
        // R6: clear event bits only, agent stays, outputs low
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'h7, "R6 clear events");
        idle_rd(4'h0, "R6 agent alone");
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'h20, "R5 partial clear");
        idle_rd(4'h0, "R5 partial");
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h0, 32'hF0, "R5 full clear");
        idle_rd(4'h0, "R5 cleared");
        // R9: rewrite both enables, check readback
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h4, 32'hFFFF_FFFC, "R9 ie write");
        step(3'b000, 4'h0, 1'b1, 1'b0, 4'h8, 32'h0000_0003, "R9 he write");
        idle_rd(4'h4, "R9 ie read");
        idle_rd(4'h8, "R9 he read");
        step(3'b001, 4'h0, 1'b0, 1'b0, 4'h0, 32'h0, "R8 crc halts now");
        idle_rd(4'h0, "R7 crc masked irq");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            int k = $urandom_range(0, 4);
            a = (k == 0) ? 4'h0 : (k == 1) ? 4'h4 : (k == 2) ? 4'h8 : (k == 3) ? 4'hC : 4'(2 * $urandom_range(0, 7) + 1);
            step(($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000, 4'($urandom),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, $urandom,
                 "R7 random");
        end
        // R1: synchronous reset mid-run
        rst_n = 1'b0;
        step(3'b111, 4'h3, 1'b0, 1'b0, 4'h0, 32'h0, "R1 in reset");
        rst_n = 1'b1;
        idle_rd(4'h0, "R1 status after reset");
        idle_rd(4'h4, "R1 ie after reset");
        idle_rd(4'h8, "R1 he after reset");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule